// File: doc/BRIEF.md
# Low-pass sub-band two-stage decimator

This block turns the single-bit sigma-delta stream of the lowest sub-band branch into a multi-bit signed sample stream at one sixteenth of the input rate. With a 72 MHz modulator it produces 4.5 MHz output. The block does no frequency shifting. The sixteen-fold rate reduction happens in two steps. A first low-pass FIR keeps one result in eight. A second, longer low-pass FIR then keeps one result in two. The second FIR also sets the sub-band edge: its skirt is meant to cross the neighbouring band-pass branch's response close to −6 dB, so that the sum of the branches stays flat to within about 2 dB.

Each stage works out only the samples it keeps. The first stage sees ±1 inputs, so it needs only additions and subtractions. A configurable register delay sits at the output. It lets the total latency equal that of the band-pass branches, so a plain adder can sum all sub-bands. Coefficients are fixed symmetric triangles made at elaboration, so the arithmetic can be checked exactly.

Top module: `lpsub_decim`

## Requirements
- R1: While `rst` is high, and after it falls, `out_vld` stays low until enough accepted inputs have arrived to fill both filter windows.
- R2: An accepted input bit of 1 counts as +1 and a bit of 0 counts as −1. Number the accepted inputs from 0, counting from reset. The first stage makes a sample at every input index i with i mod 8 = 7 and i ≥ 29. That sample is the sum over k = 0..29 of (1 + min(k, 29−k)) · x[i−k].
- R3: Number the first-stage samples from 0. The second stage makes an output at every sample index j that is odd with j ≥ 82. That output is the sum over k = 0..82 of (1 + min(k, 82−k)) · s[j−k]. This output is what appears on `out_data`.
- R4: Once the windows are full, exactly one output comes out per 16 accepted inputs. The first output covers input index 695.
- R5: While `in_vld` is low, `in_bit` is ignored. It neither shifts a window nor advances a decimation phase.
- R6: With the default alignment of 3 registers, `out_vld` rises on the fourth clock edge after the edge that accepts the last input of an output's window.
- R7: The reset is synchronous. It clears both windows, both phase counters and the alignment line. If it arrives in the same cycle as the input that would finish an output, no output comes out, and counting starts again from index 0.
- R8: `out_vld` is a one-cycle pulse. It is never high in two consecutive cycles.
- R9: The output never overflows. An all-ones stream gives +423360 and an all-zeros stream gives −423360.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Modulator bit (1 = +1, 0 = −1) |
| in_vld | input | 1 | Qualifies `in_bit` |
| out_data | output | OUT_W (20) | Signed decimated sample |
| out_vld | output | 1 | One-cycle strobe for `out_data` |

## Verification
Two events can fall in the same clock cycle: the reset, and the acceptance of the input that completes the first output window. The bench streams exactly 695 inputs and then presents input 695 with `rst` raised in that same cycle. It then watches the output for several idle cycles and expects no strobe. After that it streams a fresh sequence with no further reset. Every output must match a model started from index 0, which shows that the reset won the collision and left no state behind.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

   // Symmetric triangular tap weight: 1 at both ends, peak at the centre.
   function automatic int tri_coef(input int k, input int n);
      int m;
      m = (k < (n - 1 - k)) ? k : (n - 1 - k);
      return 1 + m;
   endfunction

   function automatic longint tri_sum(input int n);
      longint s;
      s = 0;
      for (int k = 0; k < n; k++) s += longint'(tri_coef(k, n));
      return s;
   endfunction

   // Signed width able to hold +/- m.
   function automatic int bits_for(input longint m);
      return $clog2(m + 1) + 1;
   endfunction

endpackage

// File: rtl/lpd_fir_dec.sv
module lpd_fir_dec
   import lpd_pkg::*;
#(
   parameter int N_TAPS = 30,
   parameter int DEC    = 8,
   parameter int IW     = 1,
   parameter int OW     = 9
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [IW-1:0]        i_data,
   input  logic                 i_vld,
   output logic signed [OW-1:0] o_data,
   output logic                 o_vld
);
   localparam int     PW     = (DEC > 1) ? $clog2(DEC) : 1;
   localparam int     FW     = (N_TAPS > 1) ? $clog2(N_TAPS) : 1;
   localparam longint IN_MAG = (IW == 1) ? longint'(1) : (longint'(1) << (IW - 1));
   localparam int     OW_MIN = bits_for(tri_sum(N_TAPS) * IN_MAG);

   generate
      if (N_TAPS < 2 || DEC < 2 || IW < 1 || OW < OW_MIN) begin : g_bad_cfg
         $error("lpd_fir_dec: illegal parameter set");
      end
   endgenerate

   logic [IW-1:0]        win_q [N_TAPS];
   logic [IW-1:0]        win_d [N_TAPS];
   logic [PW-1:0]        ph_q;
   logic [FW-1:0]        fill_q;
   logic signed [OW-1:0] acc;
   logic                 last_ph;
   logic                 full;

   always_comb begin
      win_d[0] = i_data;
      for (int k = 1; k < N_TAPS; k++) win_d[k] = win_q[k-1];
   end

   generate
      if (IW == 1) begin : g_addsub
         // single-bit input: each tap adds or subtracts its weight
         always_comb begin
            acc = '0;
            for (int k = 0; k < N_TAPS; k++) begin
               if (win_d[k][0]) acc = acc + OW'(tri_coef(k, N_TAPS));
               else             acc = acc - OW'(tri_coef(k, N_TAPS));
            end
         end
      end else begin : g_mac
         always_comb begin
            acc = '0;
            for (int k = 0; k < N_TAPS; k++)
               acc = acc + OW'($signed(win_d[k])) * OW'(tri_coef(k, N_TAPS));
         end
      end
   endgenerate

   assign last_ph = (ph_q == PW'(DEC - 1));
   assign full    = (fill_q == FW'(N_TAPS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < N_TAPS; k++) win_q[k] <= '0;
         ph_q   <= '0;
         fill_q <= '0;
         o_vld  <= 1'b0;
         o_data <= '0;
      end else begin
         o_vld <= 1'b0;
         if (i_vld) begin
            for (int k = 0; k < N_TAPS; k++) win_q[k] <= win_d[k];
            ph_q <= last_ph ? '0 : ph_q + PW'(1);
            if (!full) fill_q <= fill_q + FW'(1);
            if (last_ph && full) begin
               o_vld  <= 1'b1;
               o_data <= acc;
            end
         end
      end
   end

   AST_STAGE_PULSE: assert property (@(posedge clk) disable iff (rst) o_vld |=> !o_vld); // R8
   AST_STAGE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst) o_vld |-> $past(i_vld)); // R5
   AST_STAGE_RST_QUIET: assert property (@(posedge clk) rst |=> !o_vld); // R7

endmodule

// File: rtl/lpd_align.sv
module lpd_align #(
   parameter int     DLY = 3,
   parameter int     W   = 20,
   parameter longint LIM = 423360
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] i_data,
   input  logic                i_vld,
   output logic signed [W-1:0] o_data,
   output logic                o_vld
);
   generate
      if (DLY < 0) begin : g_bad_cfg
         $error("lpd_align: DLY must not be negative");
      end
      if (DLY == 0) begin : g_pass
         assign o_data = i_data;
         assign o_vld  = i_vld;
      end else begin : g_line
         logic signed [W-1:0] d_q [DLY];
         logic [DLY-1:0]      v_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               v_q <= '0;
               for (int k = 0; k < DLY; k++) d_q[k] <= '0;
            end else begin
               v_q[0] <= i_vld;
               d_q[0] <= i_data;
               for (int k = 1; k < DLY; k++) begin
                  v_q[k] <= v_q[k-1];
                  d_q[k] <= d_q[k-1];
               end
            end
         end
         assign o_data = d_q[DLY-1];
         assign o_vld  = v_q[DLY-1];
      end
   endgenerate

   AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst) o_vld |=> !o_vld); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      o_vld |-> (longint'(o_data) <= LIM && longint'(o_data) >= -LIM)); // R9

endmodule

// File: rtl/lpsub_decim.sv
module lpsub_decim
   import lpd_pkg::*;
#(
   parameter int S1_TAPS   = 30,
   parameter int S1_DEC    = 8,
   parameter int S2_TAPS   = 83,
   parameter int S2_DEC    = 2,
   parameter int ALIGN_DLY = 3,
   parameter int OUT_W     = 20
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_bit,
   input  logic                    in_vld,
   output logic signed [OUT_W-1:0] out_data,
   output logic                    out_vld
);
   localparam longint S1_MAX = tri_sum(S1_TAPS);
   localparam int     S1_W   = bits_for(S1_MAX);
   localparam longint S2_MAX = S1_MAX * tri_sum(S2_TAPS);
   localparam int     S2_W   = bits_for(S2_MAX);

   generate
      if (OUT_W < S2_W) begin : g_bad_cfg
         $error("lpsub_decim: OUT_W too narrow for the filter gain");
      end
   endgenerate

   logic signed [S1_W-1:0]  s1_data;
   logic                    s1_vld;
   logic signed [OUT_W-1:0] s2_data;
   logic                    s2_vld;

   lpd_fir_dec #(.N_TAPS(S1_TAPS), .DEC(S1_DEC), .IW(1), .OW(S1_W)) u_stage1 (
      .clk(clk), .rst(rst), .i_data(in_bit), .i_vld(in_vld),
      .o_data(s1_data), .o_vld(s1_vld));

   lpd_fir_dec #(.N_TAPS(S2_TAPS), .DEC(S2_DEC), .IW(S1_W), .OW(OUT_W)) u_stage2 (
      .clk(clk), .rst(rst), .i_data(s1_data), .i_vld(s1_vld),
      .o_data(s2_data), .o_vld(s2_vld));

   lpd_align #(.DLY(ALIGN_DLY), .W(OUT_W), .LIM(S2_MAX)) u_align (
      .clk(clk), .rst(rst), .i_data(s2_data), .i_vld(s2_vld),
      .o_data(out_data), .o_vld(out_vld));

   AST_RST_OUT_QUIET: assert property (@(posedge clk) rst |=> !out_vld); // R1

endmodule

// File: tb/sim_lpsub_decim.sv
module sim_lpsub_decim;
   localparam int  ALIGN   = 3;
   localparam int  W       = 20;
   localparam int  NIN     = 744;
   localparam int  NOUT    = 4;
   localparam int  WD_LIMIT = 150000;
   // {kind[3:0], flags[3:0] (bit0 gaps, bit1 full-scale check), expected[23:0]}
   localparam logic [31:0] VEC [6] = '{
      {4'd0, 4'b0010, 24'h0675C0},
      {4'd1, 4'b0010, 24'hF98A40},
      {4'd2, 4'b0000, 24'h000000},
      {4'd3, 4'b0000, 24'h000000},
      {4'd4, 4'b0001, 24'h000000},
      {4'd3, 4'b0001, 24'h000000}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_bit = 1'b0;
   logic in_vld = 1'b0;
   logic signed [W-1:0] out_data;
   logic out_vld;

   lpsub_decim u0 (.clk(clk), .rst(rst), .in_bit(in_bit), .in_vld(in_vld),
                   .out_data(out_data), .out_vld(out_vld));

   always #10 clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   int xs [NIN];
   longint s1m [100];
   longint expq [8];
   longint got [16];
   int nexp, ngot, first_out, last_acc, first_in, early, pulse_err;
   bit prev_vld;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int wt(input int k, input int n);
      return (k < n - 1 - k) ? k + 1 : n - k;
   endfunction

   function automatic bit gen_bit(input int kind, input int i);
      logic [31:0] h;
      h = i * 32'd2654435761;
      case (kind)
         0: return 1'b1;
         1: return 1'b0;
         2: return i[0];
         3: return h[15];
         default: return (i % 24) < 16;
      endcase
   endfunction

   task automatic build_model(input int kind);
      int j;
      j = 0; nexp = 0; first_in = -1;
      for (int i = 0; i < NIN; i++) begin
         xs[i] = gen_bit(kind, i) ? 1 : -1;
         if (i % 8 == 7 && i >= 29) begin
            longint s;
            s = 0;
            for (int k = 0; k < 30; k++) s += longint'(wt(k, 30) * xs[i-k]);
            s1m[j] = s;
            if (j % 2 == 1 && j >= 82) begin
               longint o;
               o = 0;
               for (int k = 0; k < 83; k++) o += longint'(wt(k, 83)) * s1m[j-k];
               if (nexp < 8) expq[nexp] = o;
               if (first_in < 0) first_in = i;
               nexp++;
            end
            j++;
         end
      end
   endtask

   task automatic step(input bit r, input bit v, input bit b);
      @(negedge clk);
      if (out_vld) begin
         if (ngot < 16) got[ngot] = longint'(out_data);
         if (first_out < 0) first_out = cyc;
         if (last_acc < 0) early++;
         ngot++;
      end
      if (out_vld && prev_vld) pulse_err++;
      prev_vld = out_vld;
      rst = r; in_vld = v; in_bit = b;
   endtask

   task automatic clear_capture();
      ngot = 0; first_out = -1; last_acc = -1; early = 0; pulse_err = 0;
   endtask

   task automatic reset_dut();
      repeat (3) step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      chk(out_vld == 1'b0, "R1 out_vld during reset", out_vld, 0);
   endtask

   task automatic stream(input int kind, input bit gaps);
      int i, s;
      bit v, b;
      build_model(kind);
      i = 0; s = 0;
      while (i < NIN) begin
         v = gaps ? (s % 3 != 1) : 1'b1;
         b = gen_bit(kind, i);
         step(1'b0, v, v ? b : ~b);   // invalid cycles carry the inverted bit (R5)
         if (v) begin
            if (i == first_in) last_acc = cyc;
            i++;
         end
         s++;
      end
      repeat (8) step(1'b0, 1'b0, 1'b0);
   endtask

   task automatic judge(input string what);
      chk(ngot == NOUT && nexp == NOUT, {"R4 output count ", what}, ngot, NOUT);
      chk(first_in == 695, "R4 first window end index", first_in, 695);
      for (int k = 0; k < NOUT && k < ngot; k++)
         chk(got[k] == expq[k], {"R2 R3 R5 sample value ", what}, got[k], expq[k]);
      chk(early == 0, "R1 no output before windows fill", early, 0);
      chk(first_out - last_acc == 2 + ALIGN, "R6 latency", first_out - last_acc, 2 + ALIGN);
      chk(pulse_err == 0, "R8 single-cycle strobe", pulse_err, 0);
   endtask

   initial begin
      prev_vld = 1'b0;
      clear_capture();
      for (int e = 0; e < 6; e++) begin
         int kind;
         bit gaps, full;
         logic signed [23:0] fs;
         kind = int'(VEC[e][31:28]);
         gaps = VEC[e][24];
         full = VEC[e][25];
         fs   = VEC[e][23:0];
         reset_dut();
         clear_capture();
         stream(kind, gaps);
         judge($sformatf("vector %0d", e));
         if (full) chk(got[0] == longint'(fs) && got[NOUT-1] == longint'(fs),
                       "R9 full-scale value", got[0], longint'(fs));
      end

      // R7: reset collides with the input that completes the first output
      reset_dut();
      clear_capture();
      build_model(3);
      for (int i = 0; i < 695; i++) step(1'b0, 1'b1, gen_bit(3, i));
      step(1'b1, 1'b1, gen_bit(3, 695));
      repeat (12) step(1'b0, 1'b0, 1'b0);
      chk(ngot == 0, "R7 no output after colliding reset", ngot, 0);
      clear_capture();
      stream(3, 1'b0);
      judge("after colliding reset R7");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule